// File: doc/BRIEF.md
# Channel Status Burst Responder

This block serves a host that polls the live state of a 34-channel capture front end. Commands arrive as a byte stream of 16-bit little-endian words, with a valid/ready handshake. When the block recognises the poll command, it captures the command's 32-bit length argument. It then streams back a fixed-format burst of 64-bit status words on an outgoing byte stream that also uses valid/ready.

The burst has up to ten words. The enable-mask register goes in one slot and the capture-size value in another. A snapshot of the synchronized channel levels fills two further slots. All other words are zero. Every word leaves the block in a scrambled byte order. The snapshot, the mask and the capture size are all latched once per command, so nothing inside a burst can tear. While a burst is pending, the command side stays closed.

Top module: `chan_status_responder`

## Requirements
- R1: A poll command is six bytes. The first two bytes are the ID: 0x08, then 0x00. The next four bytes are the length argument L, sent in this order: L[23:16], L[31:24], L[7:0], L[15:8].
- R2: The block checks the ID once its second byte arrives. If the ID is not 0x0008, the two bytes are discarded, nothing is sent, and the next byte is treated as the first byte of a new ID.
- R3: The response holds min(L,10) words of 8 bytes each. When L = 0, no byte is sent.
- R4: Word 0 holds the enable mask in bits 33:0, with bit 0 for channel 1 and bit 33 for channel 34. Bits 63:34 are zero.
- R5: The low 32 bits of word 5 equal the capture-size input, which counts 36-bit sample words. The high 32 bits are zero.
- R6: Words 8 and 9 both hold the synchronized channel levels in bits 33:0, with 1 meaning high and bit 0 for channel 1. The two words are identical, and their upper bits are zero.
- R7: Words 1, 2, 3, 4, 6 and 7 are all zero.
- R8: The bytes of each word go out in this lane order: bits 23:16, 31:24, 7:0, 15:8, 55:48, 63:56, 39:32, 47:40.
- R9: While rsp_valid is high and rsp_ready is low, rsp_valid stays high and rsp_data holds its value.
- R10: cmd_ready is low from the cycle after the final command byte is accepted until the final response byte has been transferred. It is never high while rsp_valid is high.
- R11: After reset, rsp_valid is 0 and cmd_ready is 1.
- R12: The mask, the capture size and the channel snapshot are taken on the cycle after the final command byte. Changes to these inputs after that point do not alter the burst in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_data | input | 8 | Command stream byte |
| cmd_valid | input | 1 | Command byte valid |
| cmd_ready | output | 1 | Block can take a command byte |
| ch_in | input | NUM_CH (34) | Raw asynchronous channel levels |
| en_mask | input | NUM_CH (34) | Channel enable mask register |
| cap_size | input | CAP_W (32) | Capture size in sample words |
| rsp_data | output | 8 | Response stream byte |
| rsp_valid | output | 1 | Response byte valid |
| rsp_ready | input | 1 | Downstream can take a response byte |

## Verification
The bench drives length arguments chosen so that an error in the order of the length bytes shows up:
- A value of 0x00030000 must produce a full ten-word burst. A block that swapped the two 16-bit halves would send three words instead.
- Lengths of 0 and 12 check the clipping and the empty burst. A wrong clip would run past the last defined slot or send a spurious word.

A rejected ID followed by a valid command catches a parser that fails to resynchronise; such a parser would drop or shift the real command. Response backpressure in a stalling pattern exposes a byte that is lost or repeated at a word boundary. Changing the inputs mid-burst exposes a design that reads the mask, the capture size or the channel levels live instead of from its snapshot.

// File: rtl/csr_pkg.sv
package csr_pkg;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_SEND  = 2'd1,
    TX_DRAIN = 2'd2
  } tx_state_t;

  // Position in the outgoing byte sequence -> byte lane of the 64-bit word
  // (lane 0 = bits 7:0). Sequence of lanes: 2,3,0,1,6,7,4,5.
  function automatic logic [2:0] lane_of(input logic [2:0] pos);
    return pos ^ 3'b010;
  endfunction

endpackage

// File: rtl/csr_sync.sv
module csr_sync #(
  parameter int W = 34
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/csr_cmd_parser.sv
module csr_cmd_parser #(
  parameter logic [15:0] CMD_ID = 16'h0008,
  parameter int          LEN_W  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             done,
  output logic             go,
  output logic [LEN_W-1:0] len
);
  logic [2:0] pos_q;
  logic [7:0] id_lo_q;
  logic       busy_q;
  logic       take;

  assign in_ready = !busy_q;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q   <= '0;
      id_lo_q <= '0;
      busy_q  <= 1'b0;
      go      <= 1'b0;
      len     <= '0;
    end else begin
      go <= 1'b0;
      if (done) busy_q <= 1'b0;
      if (take) begin
        case (pos_q)
          3'd0: begin
            id_lo_q <= in_data;
            pos_q   <= 3'd1;
          end
          3'd1: pos_q <= ({in_data, id_lo_q} == CMD_ID) ? 3'd2 : 3'd0;
          3'd2: begin len[23:16] <= in_data; pos_q <= 3'd3; end
          3'd3: begin len[31:24] <= in_data; pos_q <= 3'd4; end
          3'd4: begin len[7:0]   <= in_data; pos_q <= 3'd5; end
          default: begin
            len[15:8] <= in_data;
            pos_q     <= 3'd0;
            busy_q    <= 1'b1;
            go        <= 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/csr_word_mux.sv
module csr_word_mux #(
  parameter int NUM_CH     = 34,
  parameter int CAP_W      = 32,
  parameter int IDX_W      = 4,
  parameter int MASK_SLOT  = 0,
  parameter int CAP_SLOT   = 5,
  parameter int STATE_SLOT = 8,
  parameter int COPY_SLOT  = 9
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [NUM_CH-1:0] mask,
  input  logic [CAP_W-1:0]  cap,
  input  logic [NUM_CH-1:0] levels,
  output logic [63:0]       word
);
  always_comb begin
    word = '0;
    if (idx == IDX_W'(MASK_SLOT)) begin
      word[NUM_CH-1:0] = mask;
    end else if (idx == IDX_W'(CAP_SLOT)) begin
      word[CAP_W-1:0] = cap;
    end else if (idx == IDX_W'(STATE_SLOT) || idx == IDX_W'(COPY_SLOT)) begin
      word[NUM_CH-1:0] = levels;
    end
  end
endmodule

// File: rtl/csr_burst_tx.sv
module csr_burst_tx
  import csr_pkg::*;
#(
  parameter int MAX_WORDS = 10,
  parameter int LEN_W     = 32,
  parameter int CNT_W     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [LEN_W-1:0] len,
  output logic [CNT_W-1:0] widx,
  input  logic [63:0]      word,
  output logic [7:0]       rsp_data,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             done
);
  tx_state_t        state_q;
  logic [2:0]       bpos_q;
  logic [CNT_W-1:0] nw_q;
  logic [CNT_W-1:0] clip;
  logic [2:0]       lane;
  logic             slot_free;

  assign clip      = (len > LEN_W'(MAX_WORDS)) ? CNT_W'(MAX_WORDS) : len[CNT_W-1:0];
  assign lane      = lane_of(bpos_q);
  assign slot_free = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= TX_IDLE;
      bpos_q    <= '0;
      widx      <= '0;
      nw_q      <= '0;
      rsp_data  <= '0;
      rsp_valid <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      case (state_q)
        TX_IDLE: begin
          if (go) begin
            widx   <= '0;
            bpos_q <= '0;
            nw_q   <= clip;
            if (clip == '0) done <= 1'b1;
            else            state_q <= TX_SEND;
          end
        end
        TX_SEND: begin
          if (slot_free) begin
            rsp_data  <= word[{lane, 3'b000} +: 8];
            rsp_valid <= 1'b1;
            bpos_q    <= bpos_q + 3'd1;
            if (bpos_q == 3'd7) begin
              widx <= widx + CNT_W'(1);
              if (widx == nw_q - CNT_W'(1)) state_q <= TX_DRAIN;
            end
          end
        end
        default: begin
          if (rsp_valid && rsp_ready) begin
            done    <= 1'b1;
            state_q <= TX_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/chan_status_responder.sv
module chan_status_responder #(
  parameter int          NUM_CH    = 34,
  parameter int          CAP_W     = 32,
  parameter int          MAX_WORDS = 10,
  parameter logic [15:0] CMD_ID    = 16'h0008
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        cmd_data,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [NUM_CH-1:0] ch_in,
  input  logic [NUM_CH-1:0] en_mask,
  input  logic [CAP_W-1:0]  cap_size,
  output logic [7:0]        rsp_data,
  output logic              rsp_valid,
  input  logic              rsp_ready
);
  localparam int LEN_W = 32;
  localparam int CNT_W = $clog2(MAX_WORDS + 1);

  logic [NUM_CH-1:0] ch_sync;
  logic [NUM_CH-1:0] snap_q;
  logic [NUM_CH-1:0] mask_q;
  logic [CAP_W-1:0]  cap_q;
  logic              burst_go;
  logic              burst_done;
  logic [LEN_W-1:0]  burst_len;
  logic [CNT_W-1:0]  widx;
  logic [63:0]       cur_word;

  csr_sync #(.W(NUM_CH)) u_sync (
    .clk(clk), .rst(rst), .d(ch_in), .q(ch_sync)
  );

  csr_cmd_parser #(.CMD_ID(CMD_ID), .LEN_W(LEN_W)) u_parse (
    .clk(clk), .rst(rst),
    .in_data(cmd_data), .in_valid(cmd_valid), .in_ready(cmd_ready),
    .done(burst_done), .go(burst_go), .len(burst_len)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q <= '0;
      mask_q <= '0;
      cap_q  <= '0;
    end else if (burst_go) begin
      snap_q <= ch_sync;
      mask_q <= en_mask;
      cap_q  <= cap_size;
    end
  end

  csr_word_mux #(.NUM_CH(NUM_CH), .CAP_W(CAP_W), .IDX_W(CNT_W)) u_mux (
    .idx(widx), .mask(mask_q), .cap(cap_q), .levels(snap_q), .word(cur_word)
  );

  csr_burst_tx #(.MAX_WORDS(MAX_WORDS), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_tx (
    .clk(clk), .rst(rst), .go(burst_go), .len(burst_len),
    .widx(widx), .word(cur_word),
    .rsp_data(rsp_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .done(burst_done)
  );
endmodule

// File: rtl/csr_checker.sv
module csr_checker (
  input logic        clk,
  input logic        rst,
  input logic        cmd_ready,
  input logic [7:0]  rsp_data,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic        burst_go,
  input logic [31:0] burst_len
);
  a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  a_r10_closed_while_sending: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !cmd_ready);

  a_r10_closed_at_start: assert property (@(posedge clk) disable iff (rst)
    burst_go |-> !cmd_ready);

  a_r3_zero_len_silent: assert property (@(posedge clk) disable iff (rst)
    (burst_go && burst_len == 32'd0) |=> !rsp_valid);

  a_r11_reset_idle: assert property (@(posedge clk)
    rst |=> (!rsp_valid && cmd_ready));
endmodule

bind chan_status_responder csr_checker u_chk (
  .clk(clk), .rst(rst), .cmd_ready(cmd_ready),
  .rsp_data(rsp_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .burst_go(burst_go), .burst_len(burst_len)
);

// File: tb/tb_chan_status_responder.sv
module tb_chan_status_responder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  cmd_data = '0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [33:0] ch_in = '0;
  logic [33:0] en_mask = '0;
  logic [31:0] cap_size = '0;
  logic [7:0]  rsp_data;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;

  int tests = 0;
  int fails = 0;
  int stall_mode = 0;
  int cyc = 0;
  int viol9 = 0;
  int viol10 = 0;
  logic       prev_stall = 1'b0;
  logic [7:0] prev_data = '0;
  logic [7:0] rxq[$];

  always #2 clk = ~clk;

  chan_status_responder dut (
    .clk(clk), .rst(rst), .cmd_data(cmd_data), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .ch_in(ch_in), .en_mask(en_mask),
    .cap_size(cap_size), .rsp_data(rsp_data), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready)
  );

  // Stimulus table: length, mask, capture size, channel levels, stall mode
  localparam int NT = 6;
  localparam logic [31:0] T_LEN  [NT] = '{32'd10, 32'd3, 32'h0003_0000, 32'd12, 32'd0, 32'd9};
  localparam logic [33:0] T_MASK [NT] = '{34'h2_0000_0001, 34'h1_2345_6789, 34'h0_0000_00FF,
                                          34'h3_FFFF_FFFF, 34'h1_1111_1111, 34'h0_F0F0_F0F0};
  localparam logic [31:0] T_CAP  [NT] = '{32'h0001_2345, 32'hDEAD_BEEF, 32'h8000_0001,
                                          32'h0, 32'h5, 32'h0000_0100};
  localparam logic [33:0] T_CH   [NT] = '{34'h3_FFFF_FFFF, 34'h0_5555_AAAA, 34'h2_0000_0000,
                                          34'h0_0000_0001, 34'h3_0000_0003, 34'h1_0F0F_0F0F};
  localparam int          T_MODE [NT] = '{0, 1, 1, 0, 0, 1};

  // Response side: drive ready and record transfers away from the rising edge
  always @(negedge clk) begin
    cyc++;
    if (rsp_valid && cmd_ready) viol10++;
    if (prev_stall && (!rsp_valid || rsp_data != prev_data)) viol9++;
    rsp_ready = (stall_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
    if (rsp_valid && rsp_ready) rxq.push_back(rsp_data);
    prev_stall = rsp_valid && !rsp_ready;
    prev_data  = rsp_data;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  function automatic logic [63:0] exp_word(int i, logic [33:0] m, logic [31:0] c, logic [33:0] s);
    logic [63:0] w = '0;
    if (i == 0) w[33:0] = m;
    else if (i == 5) w[31:0] = c;
    else if (i == 8 || i == 9) w[33:0] = s;
    return w;
  endfunction

  // Wire order by byte number, byte 1 = most significant
  function automatic logic [7:0] exp_byte(logic [63:0] w, int k);
    int order [8] = '{6, 5, 8, 7, 2, 1, 4, 3};
    return 8'((w >> (64 - 8 * order[k])) & 64'hFF);
  endfunction

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    cmd_data  = b;
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic send_cmd(input logic [31:0] l);
    send_byte(8'h08); send_byte(8'h00);
    send_byte(l[23:16]); send_byte(l[31:24]);
    send_byte(l[7:0]);   send_byte(l[15:8]);
  endtask

  task automatic wait_idle();
    repeat (4) @(negedge clk);
    while (!(cmd_ready && !rsp_valid)) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_burst(input logic [31:0] l, input logic [33:0] m,
                             input logic [31:0] c, input logic [33:0] s);
    int n = (l > 10) ? 10 : int'(l);
    check(rxq.size() == n * 8, "R3", "byte count", 64'(rxq.size()), 64'(n * 8));
    if (rxq.size() == n * 8) begin
      for (int i = 0; i < n; i++) begin
        logic [63:0] ew = exp_word(i, m, c, s);
        logic [63:0] got = '0;
        logic [63:0] want = '0;
        string req;
        for (int k = 0; k < 8; k++) begin
          got  = {got[55:0], rxq[i * 8 + k]};
          want = {want[55:0], exp_byte(ew, k)};
        end
        req = (i == 0) ? "R4/R8" : (i == 5) ? "R5/R8" :
              (i == 8 || i == 9) ? "R6/R8" : "R7/R8";
        check(got == want, req, $sformatf("word %0d wire bytes", i), got, want);
      end
    end
    check(cmd_ready == 1'b1, "R10", "cmd_ready after burst", 64'(cmd_ready), 64'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check(rsp_valid == 1'b0, "R11", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
    check(cmd_ready == 1'b1, "R11", "cmd_ready after reset", 64'(cmd_ready), 64'd1);

    // Table walk: R1 length field order, R3 clipping/zero, R4-R8 contents
    for (int t = 0; t < NT; t++) begin
      stall_mode = T_MODE[t];
      ch_in = T_CH[t]; en_mask = T_MASK[t]; cap_size = T_CAP[t];
      repeat (4) @(negedge clk);
      rxq.delete();
      send_cmd(T_LEN[t]);
      wait_idle();
      check_burst(T_LEN[t], T_MASK[t], T_CAP[t], T_CH[t]);
    end

    // R2: wrong ID is dropped, following valid command is served once
    stall_mode = 0;
    rxq.delete();
    send_byte(8'h07); send_byte(8'h00);
    repeat (10) @(negedge clk);
    check(rxq.size() == 0, "R2", "bytes after bad ID", 64'(rxq.size()), 64'd0);
    send_cmd(32'd10);
    wait_idle();
    check_burst(32'd10, T_MASK[5], T_CAP[5], T_CH[5]);

    // R12: inputs changed after command completion do not affect the burst
    stall_mode = 1;
    ch_in = 34'h2_AAAA_5555; en_mask = 34'h1_0000_8001; cap_size = 32'h0BAD_F00D;
    repeat (4) @(negedge clk);
    rxq.delete();
    send_cmd(32'd10);
    repeat (2) @(negedge clk);
    ch_in = 34'h1_5555_AAAA; en_mask = 34'h0; cap_size = 32'hFFFF_FFFF;
    wait_idle();
    check_burst(32'd10, 34'h1_0000_8001, 32'h0BAD_F00D, 34'h2_AAAA_5555);
    check(rxq.size() == 80, "R12", "snapshot burst length", 64'(rxq.size()), 64'd80);

    check(viol9 == 0, "R9", "data changed during stall", 64'(viol9), 64'd0);
    check(viol10 == 0, "R10", "cmd_ready high while sending", 64'(viol10), 64'd0);
    summary();
    $finish;
  end
endmodule